// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This is a purely combinational datapath unit for an integer core. A 2-bit select picks one of three functions over two 32-bit operands `a` and `b`. Two of them are ordering compares, one signed and one unsigned. Each compare returns the full difference `b - a`. When the operands' top bits differ, the top bit of the result is repaired, so that bit 31 always tells whether `b` is less than `a` under the chosen interpretation.

The third function scans the four byte lanes of the operands. It starts at the most significant lane and returns the 1-based position of the first lane where `a` and `b` hold the same byte. It returns 0 when no lane matches. The unit produces no flags, holds no state and has no clock. Its result follows its inputs within the same cycle, so it can sit directly in an execute stage.

Top module: `cmp_bytematch`

## Requirements
- R1: Select 00 is the signed compare and select 01 is the unsigned compare. When bit 31 of `a` equals bit 31 of `b`, both return `b + ~a + 1` (that is, `b - a` modulo 2^32) unchanged.
- R2: Signed compare with differing top bits: bits 30:0 of the result are bits 30:0 of `b - a`, and bit 31 is bit 31 of `b`.
- R3: Unsigned compare with differing top bits: bits 30:0 of the result are bits 30:0 of `b - a`, and bit 31 is bit 31 of `a`.
- R4: For the signed compare, result bit 31 is 1 exactly when `b` < `a` as two's-complement integers.
- R5: For the unsigned compare, result bit 31 is 1 exactly when `b` < `a` as unsigned integers.
- R6: Select 10 is the byte search. Lanes are examined in priority order: bits 31:24 first, then 23:16, then 15:8, then 7:0. The result is the value 1, 2, 3 or 4 of the first lane in which `a` and `b` are equal. All upper result bits are zero.
- R7: The byte search returns 0 when no lane of `a` equals the same lane of `b`.
- R8: Select 11 returns all zeros for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 2 | Function select: 00 signed compare, 01 unsigned compare, 10 byte search, 11 zero |
| a | input | 32 | First operand (the subtrahend for the compares) |
| b | input | 32 | Second operand (the minuend for the compares) |
| res | output | 32 | Result of the selected function |

## Verification
The sign repair only takes effect when the operands' top bits differ, and the raw subtraction then overflows. Uniform random operands hit this case about half the time, but the extremes that break a naive subtractor are rarely reached. The stimulus therefore crosses every pair of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF under both compares, in addition to random pairs. For the byte search, random operands almost never share a byte. The bench builds `b` by copying chosen lanes of `a`, so every priority combination appears, including matches in several lanes at once.

// File: rtl/cmp_bytematch.sv
module cmp_bytematch #(
  parameter int W    = 32,
  parameter int LANE = 8
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int NL = W / LANE;
  localparam int IW = $clog2(NL + 1);

  logic [W-1:0]  diff;
  logic          sgn_split;
  logic [W-1:0]  scmp;
  logic [W-1:0]  ucmp;
  logic [NL-1:0] hit;
  logic [IW-1:0] idx;

  assign diff      = b + ~a + {{(W-1){1'b0}}, 1'b1};
  assign sgn_split = a[W-1] ^ b[W-1];
  assign scmp      = sgn_split ? {b[W-1], diff[W-2:0]} : diff;
  assign ucmp      = sgn_split ? {a[W-1], diff[W-2:0]} : diff;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign hit[g] = (a[g*LANE +: LANE] == b[g*LANE +: LANE]);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NL; i++)
      if (hit[i]) idx = IW'(NL - i);
  end

  always_comb begin
    case (op)
      2'b00:   res = scmp;
      2'b01:   res = ucmp;
      2'b10:   res = W'(idx);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/cmp_bytematch_chk.sv
module cmp_bytematch_chk #(
  parameter int W    = 32,
  parameter int LANE = 8
) (
  input logic [1:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] res
);
  localparam int NL = W / LANE;

  logic [W-1:0] d;
  logic         any_eq;
  logic         sel_eq;
  assign d = b - a;

  always_comb begin
    any_eq = 1'b0;
    sel_eq = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (a[i*LANE +: LANE] == b[i*LANE +: LANE]) begin
        any_eq = 1'b1;
        if (res == W'(NL - i)) sel_eq = 1'b1;
      end
    end
  end

  always_comb begin
    if (op == 2'b00) begin
      AST_SIGNED_ORDER: assert (res[W-1] == ($signed(b) < $signed(a))) else $error("signed order"); // R4
    end
    if (op == 2'b01) begin
      AST_UNSIGNED_ORDER: assert (res[W-1] == (b < a)) else $error("unsigned order"); // R5
    end
    if (op[1] == 1'b0) begin
      AST_LOW_DIFF: assert (res[W-2:0] == d[W-2:0]) else $error("low bits"); // R2
    end
    if (op == 2'b10) begin
      AST_NO_MATCH_ZERO: assert (any_eq || res == '0) else $error("no match"); // R7
      AST_HIT_IS_EQUAL: assert (!any_eq || sel_eq) else $error("hit lane"); // R6
    end
    if (op == 2'b11) begin
      AST_SPARE_ZERO: assert (res == '0) else $error("spare select"); // R8
    end
  end
endmodule

bind cmp_bytematch cmp_bytematch_chk #(.W(W), .LANE(LANE)) u_chk (.op(op), .a(a), .b(b), .res(res));

// File: tb/sim_cmp_bytematch.sv
module sim_cmp_bytematch;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  op;
  logic [31:0] a, b, res;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  cmp_bytematch u0 (.op(op), .a(a), .b(b), .res(res));

  localparam int NV = 13;
  localparam logic [97:0] VEC [NV] = '{
    {2'd0, 32'h00000005, 32'h00000003, 32'hFFFFFFFE},
    {2'd0, 32'h00000003, 32'h00000005, 32'h00000002},
    {2'd0, 32'h80000000, 32'h00000001, 32'h00000001},
    {2'd1, 32'h80000000, 32'h00000001, 32'h80000001},
    {2'd0, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFE},
    {2'd1, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFE},
    {2'd2, 32'h11223344, 32'h11000000, 32'h00000001},
    {2'd2, 32'h11223344, 32'h00223344, 32'h00000002},
    {2'd2, 32'h11223344, 32'h00003344, 32'h00000003},
    {2'd2, 32'h11223344, 32'h00000044, 32'h00000004},
    {2'd2, 32'h11223344, 32'h44332211, 32'h00000000},
    {2'd3, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
    {2'd1, 32'h00000007, 32'h00000007, 32'h00000000}
  };

  function automatic logic [31:0] ref_search(logic [31:0] x, logic [31:0] y);
    for (int k = 0; k < 4; k++)
      if (x[31-8*k -: 8] == y[31-8*k -: 8]) return 32'(k + 1);
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic cmp_pair(logic [31:0] x, logic [31:0] y);
    logic [31:0] dd;
    dd = y - x;
    apply(2'd0, x, y);
    check("R4 signed sign", {31'd0, res[31]}, {31'd0, $signed(y) < $signed(x)});
    check(x[31] == y[31] ? "R1 signed raw" : "R2 signed low", {1'b0, res[30:0]}, {1'b0, dd[30:0]});
    if (x[31] != y[31]) check("R2 signed top", {31'd0, res[31]}, {31'd0, y[31]});
    else check("R1 signed raw", res, dd);
    apply(2'd1, x, y);
    check("R5 unsigned sign", {31'd0, res[31]}, {31'd0, y < x});
    if (x[31] != y[31]) check("R3 unsigned top", res, {x[31], dd[30:0]});
    else check("R1 unsigned raw", res, dd);
  endtask

  initial begin
    logic [31:0] cv [4];
    cv[0] = 32'h0; cv[1] = 32'h7FFFFFFF; cv[2] = 32'h80000000; cv[3] = 32'hFFFFFFFF;
    op = 2'd3; a = 32'h12345678; b = 32'h9ABCDEF0;
    @(negedge clk);
    check("R8 idle select zero", res, 32'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][97:96], VEC[v][95:64], VEC[v][63:32]);
      check("R1/R2/R3/R6/R7/R8 vector", res, VEC[v][31:0]);
    end

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        cmp_pair(cv[i], cv[j]);

    for (int r = 0; r < 400; r++)
      cmp_pair($urandom, $urandom);

    for (int r = 0; r < 400; r++) begin
      logic [31:0] x, y;
      logic [3:0] m;
      x = $urandom; y = $urandom; m = 4'($urandom);
      for (int k = 0; k < 4; k++) if (m[k]) y[8*k +: 8] = x[8*k +: 8];
      apply(2'd2, x, y);
      check(ref_search(x, y) == 0 ? "R7 search none" : "R6 search lane", res, ref_search(x, y));
    end

    for (int r = 0; r < 50; r++) begin
      apply(2'd3, $urandom, $urandom);
      check("R8 spare select", res, 32'h0);
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule